// File: doc/BRIEF.md
# Boundary Scan Register with Grouped Output Enables

This block is the data-register side of a boundary scan chain for a small device. It sits between the core logic and the pads. Each pin has its own scan cell. The chain has four kinds of cell:

- input-only capture cells;
- tri-state output cells;
- bidirectional cells;
- one internal cell that has no pin and always captures a constant 1.

At the scan-in end of the chain sit four shared control cells. Each one decides whether a whole group of outputs is driven or left at high impedance. The four groups are the address outputs, the data/parity lines, the bus cycle-definition outputs and the miscellaneous status outputs.

A test access port controller outside this block supplies the capture, shift and update strobes and a test-mode flag. When the flag is low, every pin follows the core and a capture only samples, so normal operation is not disturbed. When the flag is high, pin values and group enables come from the update latches. Those latches change only on an update strobe, so the pins hold still while a new pattern is shifted in.

The cell counts of each group are parameters. The default is a 19-cell chain.

Top module: `bsr_chain`

## Requirements
- R1: After reset, all four control update latches hold 1, so with the test flag set every group enable is 0. All other update latches and all shift stages reset to 0, so `scan_out` reads 0.
- R2: On each cycle with `shift_dr` high and `capture_dr` low, every shift stage takes the value of its neighbour on the scan-in side. The last cell takes `scan_in`, and `scan_out` always shows cell 0. After the chain length of shifts, the bit shifted in first sits in cell 0.
- R3: On a cycle with `capture_dr` high, each cell loads its capture source. Capture takes priority over shift. The sources are:
  - address, bus and miscellaneous output cells capture the core value;
  - input cells capture `pin_in`;
  - the internal cell captures 1;
  - each control cell captures the inverse of its group's core enable.
- R4: Update latches load from the shift stages only on a cycle with `update_dr` high. Shifting without an update leaves every pin value and every pin enable unchanged.
- R5: With `extest` high, each output and bidirectional pin value equals its cell's update latch.
- R6: With `extest` high, a control latch holding 1 sets that group's enable to 0, and a 0 sets it to 1. Each control affects only its own group. Control cell 15 governs the address group, 16 the data/parity group, 17 the bus group and 18 the miscellaneous group.
- R7: With `extest` low, every pin value and group enable equals the core value and the core enable, whatever the update latches hold.
- R8: A bidirectional cell captures the external `pin_data_i`, also when its group is disabled in test mode.
- R9: With the default parameters the chain has 19 cells, with cell 0 nearest `scan_out`. The layout is:
  - cells 0–2: address;
  - cells 3–6: data/parity;
  - cells 7–9: inputs;
  - cells 10–11: bus;
  - cells 12–13: miscellaneous;
  - cell 14: internal constant;
  - cells 15–18: controls.
- R10: `core_in` always equals `pin_in`, and `core_data_i` always equals `pin_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low reset |
| scan_in | input | 1 | Serial data into the last cell |
| scan_out | output | 1 | Serial data from cell 0 |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| extest | input | 1 | Test mode: pins driven from update latches |
| pin_in | input | N_IN | Input-only pins |
| core_in | output | N_IN | Input pins passed to the core |
| core_addr | input | N_ADDR | Core address values |
| core_addr_oe | input | 1 | Core address enable |
| pin_addr_o | output | N_ADDR | Address pin values |
| pin_addr_oe | output | 1 | Address group enable |
| core_data_o | input | N_DATA | Core data/parity values |
| core_data_oe | input | 1 | Core data enable |
| pin_data_i | input | N_DATA | Data/parity values seen at the pads |
| core_data_i | output | N_DATA | Pad data passed to the core |
| pin_data_o | output | N_DATA | Data/parity pin values |
| pin_data_oe | output | 1 | Data group enable |
| core_busc | input | N_BUSC | Core bus cycle-definition values |
| core_busc_oe | input | 1 | Core bus group enable |
| pin_busc_o | output | N_BUSC | Bus cycle-definition pin values |
| pin_busc_oe | output | 1 | Bus group enable |
| core_misc | input | N_MISC | Core status values |
| core_misc_oe | input | 1 | Core status enable |
| pin_misc_o | output | N_MISC | Status pin values |
| pin_misc_oe | output | 1 | Status group enable |

## Verification
Captures are tried with several mixes of core values, pad values and core enables. Every cell position takes distinct values across the mixes, so a swapped or misrouted capture source stands out.

Four load patterns put the control nibble at 0000, 1111, 0100 and 1001. They separate a control that reaches the wrong group from one that inverts the wrong way.

A pattern is shifted in and then shifted out again. This shows the chain order and shows that the constant cell holds 1.

A shift with no update, and a run with the test flag low, show that shifting does not change the pins and that normal operation takes no notice of the latches.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   localparam int N_GROUPS = 4;
   typedef enum logic [1:0] {
      GRP_ADDR = 2'd0,
      GRP_DATA = 2'd1,
      GRP_BUSC = 2'd2,
      GRP_MISC = 2'd3
   } grp_e;
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
   parameter bit RST_UPD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic capture_dr,
   input  logic shift_dr,
   input  logic update_dr,
   input  logic cap_val,
   input  logic ser_in,
   output logic stage_q,
   output logic upd_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= 1'b0;
         upd_q   <= RST_UPD;
      end else begin
         if (capture_dr)    stage_q <= cap_val;
         else if (shift_dr) stage_q <= ser_in;
         if (update_dr)     upd_q   <= stage_q;
      end
   end

   AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !update_dr |=> $stable(upd_q)); // R4
   AST_UPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      update_dr |=> (upd_q == $past(stage_q))); // R4
   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_dr && !capture_dr) |=> (stage_q == $past(ser_in))); // R2
endmodule

// File: rtl/bsr_grp_drv.sv
module bsr_grp_drv #(
   parameter int W = 2
) (
   input  logic         extest,
   input  logic [W-1:0] core_val,
   input  logic         core_oe,
   input  logic [W-1:0] upd_val,
   input  logic         dis,
   output logic [W-1:0] pin_val,
   output logic         pin_oe
);
   if (W < 1) begin : g_bad_w
      $error("bsr_grp_drv: W must be at least 1");
   end

   assign pin_val = extest ? upd_val : core_val;
   assign pin_oe  = extest ? ~dis    : core_oe;

   always_comb begin
      if (extest && dis) begin
         AST_GROUP_HIZ: assert (!pin_oe); // R6
      end
   end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
   import bsr_pkg::*;
#(
   parameter int N_ADDR = 3,
   parameter int N_DATA = 4,
   parameter int N_IN   = 3,
   parameter int N_BUSC = 2,
   parameter int N_MISC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_in,
   output logic              scan_out,
   input  logic              capture_dr,
   input  logic              shift_dr,
   input  logic              update_dr,
   input  logic              extest,
   input  logic [N_IN-1:0]   pin_in,
   output logic [N_IN-1:0]   core_in,
   input  logic [N_ADDR-1:0] core_addr,
   input  logic              core_addr_oe,
   output logic [N_ADDR-1:0] pin_addr_o,
   output logic              pin_addr_oe,
   input  logic [N_DATA-1:0] core_data_o,
   input  logic              core_data_oe,
   input  logic [N_DATA-1:0] pin_data_i,
   output logic [N_DATA-1:0] core_data_i,
   output logic [N_DATA-1:0] pin_data_o,
   output logic              pin_data_oe,
   input  logic [N_BUSC-1:0] core_busc,
   input  logic              core_busc_oe,
   output logic [N_BUSC-1:0] pin_busc_o,
   output logic              pin_busc_oe,
   input  logic [N_MISC-1:0] core_misc,
   input  logic              core_misc_oe,
   output logic [N_MISC-1:0] pin_misc_o,
   output logic              pin_misc_oe
);
   // Chain layout, cell 0 nearest scan_out (R9)
   localparam int OFF_ADDR  = 0;
   localparam int OFF_DATA  = OFF_ADDR + N_ADDR;
   localparam int OFF_IN    = OFF_DATA + N_DATA;
   localparam int OFF_BUSC  = OFF_IN + N_IN;
   localparam int OFF_MISC  = OFF_BUSC + N_BUSC;
   localparam int OFF_CONST = OFF_MISC + N_MISC;
   localparam int OFF_CTRL  = OFF_CONST + 1;
   localparam int CHAIN_LEN = OFF_CTRL + N_GROUPS;

   if (N_ADDR < 1 || N_DATA < 1 || N_IN < 1 || N_BUSC < 1 || N_MISC < 1) begin : g_bad_cfg
      $error("bsr_chain: every group needs at least one cell");
   end

   logic [CHAIN_LEN-1:0] cap_vec;
   logic [CHAIN_LEN-1:0] ser_vec;
   logic [CHAIN_LEN-1:0] stage_vec;
   logic [CHAIN_LEN-1:0] upd_vec;
   logic [N_GROUPS-1:0]  core_oe_vec;

   assign core_oe_vec[GRP_ADDR] = core_addr_oe;
   assign core_oe_vec[GRP_DATA] = core_data_oe;
   assign core_oe_vec[GRP_BUSC] = core_busc_oe;
   assign core_oe_vec[GRP_MISC] = core_misc_oe;

   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      if (i < OFF_DATA) begin : g_addr
         assign cap_vec[i] = core_addr[i-OFF_ADDR];
      end else if (i < OFF_IN) begin : g_data
         assign cap_vec[i] = pin_data_i[i-OFF_DATA];
      end else if (i < OFF_BUSC) begin : g_in
         assign cap_vec[i] = pin_in[i-OFF_IN];
      end else if (i < OFF_MISC) begin : g_busc
         assign cap_vec[i] = core_busc[i-OFF_BUSC];
      end else if (i < OFF_CONST) begin : g_misc
         assign cap_vec[i] = core_misc[i-OFF_MISC];
      end else if (i == OFF_CONST) begin : g_const
         assign cap_vec[i] = 1'b1;
      end else begin : g_ctrl
         assign cap_vec[i] = ~core_oe_vec[i-OFF_CTRL];
      end

      if (i == CHAIN_LEN - 1) begin : g_head
         assign ser_vec[i] = scan_in;
      end else begin : g_link
         assign ser_vec[i] = stage_vec[i+1];
      end

      bsr_cell #(.RST_UPD(i >= OFF_CTRL)) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .capture_dr (capture_dr),
         .shift_dr   (shift_dr),
         .update_dr  (update_dr),
         .cap_val    (cap_vec[i]),
         .ser_in     (ser_vec[i]),
         .stage_q    (stage_vec[i]),
         .upd_q      (upd_vec[i])
      );
   end

   assign scan_out    = stage_vec[0];
   assign core_in     = pin_in;
   assign core_data_i = pin_data_i;

   bsr_grp_drv #(.W(N_ADDR)) u_drv_addr (
      .extest (extest), .core_val (core_addr), .core_oe (core_addr_oe),
      .upd_val (upd_vec[OFF_ADDR +: N_ADDR]), .dis (upd_vec[OFF_CTRL+GRP_ADDR]),
      .pin_val (pin_addr_o), .pin_oe (pin_addr_oe));

   bsr_grp_drv #(.W(N_DATA)) u_drv_data (
      .extest (extest), .core_val (core_data_o), .core_oe (core_data_oe),
      .upd_val (upd_vec[OFF_DATA +: N_DATA]), .dis (upd_vec[OFF_CTRL+GRP_DATA]),
      .pin_val (pin_data_o), .pin_oe (pin_data_oe));

   bsr_grp_drv #(.W(N_BUSC)) u_drv_busc (
      .extest (extest), .core_val (core_busc), .core_oe (core_busc_oe),
      .upd_val (upd_vec[OFF_BUSC +: N_BUSC]), .dis (upd_vec[OFF_CTRL+GRP_BUSC]),
      .pin_val (pin_busc_o), .pin_oe (pin_busc_oe));

   bsr_grp_drv #(.W(N_MISC)) u_drv_misc (
      .extest (extest), .core_val (core_misc), .core_oe (core_misc_oe),
      .upd_val (upd_vec[OFF_MISC +: N_MISC]), .dis (upd_vec[OFF_CTRL+GRP_MISC]),
      .pin_val (pin_misc_o), .pin_oe (pin_misc_oe));

   AST_CONST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      capture_dr |=> stage_vec[OFF_CONST]); // R3
   AST_NORMAL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      !extest |-> (pin_addr_o == core_addr && pin_busc_o == core_busc
                   && pin_misc_o == core_misc && pin_data_o == core_data_o)); // R7
endmodule

// File: tb/bsr_chain_bench.sv
module bsr_chain_bench;
   localparam int L = 19;

   typedef struct packed {
      logic [2:0]  p_in;
      logic [2:0]  c_addr;
      logic [3:0]  c_data;
      logic [3:0]  p_data;
      logic [1:0]  c_busc;
      logic [1:0]  c_misc;
      logic [3:0]  c_oe;   // {misc, busc, data, addr}
      logic [18:0] load;
   } vec_t;

   localparam vec_t TBL [0:3] = '{
      '{3'b101, 3'b011, 4'b1100, 4'b0101, 2'b10, 2'b01, 4'b1111, 19'h05A5A},
      '{3'b010, 3'b100, 4'b0011, 4'b1010, 2'b01, 2'b10, 4'b0000, 19'h7FFFF},
      '{3'b111, 3'b001, 4'b1001, 4'b0110, 2'b11, 2'b00, 4'b1010, 19'h23C96},
      '{3'b000, 3'b110, 4'b0110, 4'b1111, 2'b00, 2'b11, 4'b0101, 19'h4A6B1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic scan_in = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, extest = 1'b0;
   logic scan_out;
   logic [2:0] pin_in = '0, core_in, core_addr = '0, pin_addr_o;
   logic core_addr_oe = 1'b0, core_data_oe = 1'b0, core_busc_oe = 1'b0, core_misc_oe = 1'b0;
   logic pin_addr_oe, pin_data_oe, pin_busc_oe, pin_misc_oe;
   logic [3:0] core_data_o = '0, pin_data_i = '0, core_data_i, pin_data_o;
   logic [1:0] core_busc = '0, pin_busc_o, core_misc = '0, pin_misc_o;

   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   bsr_chain u_bsr_chain (
      .clk, .rst_n, .scan_in, .scan_out, .capture_dr, .shift_dr, .update_dr, .extest,
      .pin_in, .core_in, .core_addr, .core_addr_oe, .pin_addr_o, .pin_addr_oe,
      .core_data_o, .core_data_oe, .pin_data_i, .core_data_i, .pin_data_o, .pin_data_oe,
      .core_busc, .core_busc_oe, .pin_busc_o, .pin_busc_oe,
      .core_misc, .core_misc_oe, .pin_misc_o, .pin_misc_oe);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic scan(input logic do_cap, input logic [L-1:0] din, output logic [L-1:0] dout);
      if (do_cap) begin
         capture_dr = 1'b1;
         @(negedge clk);
         capture_dr = 1'b0;
      end
      shift_dr = 1'b1;
      for (int i = 0; i < L; i++) begin
         dout[i] = scan_out;
         scan_in = din[i];
         @(negedge clk);
      end
      shift_dr = 1'b0;
   endtask

   task automatic update();
      update_dr = 1'b1;
      @(negedge clk);
      update_dr = 1'b0;
   endtask

   // Packs the pin side as {misc_oe,busc_oe,data_oe,addr_oe, misc, busc, data, addr}
   function automatic logic [31:0] pins();
      return {17'd0, pin_misc_oe, pin_busc_oe, pin_data_oe, pin_addr_oe,
              pin_misc_o, pin_busc_o, pin_data_o, pin_addr_o};
   endfunction

   function automatic logic [31:0] exp_ext(input logic [18:0] p);
      return {17'd0, ~p[18], ~p[17], ~p[16], ~p[15], p[13:12], p[11:10], p[6:3], p[2:0]};
   endfunction

   function automatic logic [18:0] exp_cap(input vec_t v);
      return {~v.c_oe[3], ~v.c_oe[2], ~v.c_oe[1], ~v.c_oe[0], 1'b1,
              v.c_misc, v.c_busc, v.p_in, v.p_data, v.c_addr};
   endfunction

   initial begin
      logic [L-1:0] got;
      logic [31:0]  snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      extest = 1'b1;
      @(negedge clk);
      chk("R1 reset enables off", {28'd0, pin_misc_oe, pin_busc_oe, pin_data_oe, pin_addr_oe}, 32'd0);
      chk("R1 reset scan_out", {31'd0, scan_out}, 32'd0);
      chk("R1 reset latch values", {21'd0, pin_misc_o, pin_busc_o, pin_data_o, pin_addr_o}, 32'd0);
      extest = 1'b0;

      // Table walk: R3 capture, R5/R6 test-mode drive, R9 layout
      foreach (TBL[k]) begin
         pin_in = TBL[k].p_in; core_addr = TBL[k].c_addr; core_data_o = TBL[k].c_data;
         pin_data_i = TBL[k].p_data; core_busc = TBL[k].c_busc; core_misc = TBL[k].c_misc;
         {core_misc_oe, core_busc_oe, core_data_oe, core_addr_oe} = TBL[k].c_oe;
         extest = 1'b0;
         scan(1'b1, TBL[k].load, got);
         chk("R3/R9 capture vector", {13'd0, got}, {13'd0, exp_cap(TBL[k])});
         chk("R10 passthrough", {25'd0, core_in, core_data_i}, {25'd0, pin_in, pin_data_i});
         update();
         extest = 1'b1;
         #1;
         chk("R5/R6 extest pins", pins(), exp_ext(TBL[k].load));
      end

      // R4: shifting without update leaves pins alone
      scan(1'b0, 19'h05A5A, got);
      update();
      snap = pins();
      scan(1'b0, 19'h70F0F, got);
      chk("R4 pins held during shift", pins(), snap);
      chk("R4 no update", pins(), exp_ext(19'h05A5A));
      update();
      chk("R4 update applies", pins(), exp_ext(19'h70F0F));

      // R7: normal mode follows the core whatever the latches hold
      extest = 1'b0;
      core_addr = 3'b010; core_data_o = 4'b1101; core_busc = 2'b01; core_misc = 2'b10;
      {core_misc_oe, core_busc_oe, core_data_oe, core_addr_oe} = 4'b0110;
      #1;
      chk("R7 normal pins", pins(), {17'd0, 4'b0110, 2'b10, 2'b01, 4'b1101, 3'b010});

      // R8: disabled bidirectional group captures the external pad value
      scan(1'b0, 19'h10000, got);
      update();
      extest = 1'b1;
      pin_data_i = 4'b1001;
      core_data_o = 4'b0110;
      #1;
      chk("R8 data group off", {31'd0, pin_data_oe}, 32'd0);
      chk("R6 addr group on", {31'd0, pin_addr_oe}, 32'd1);
      scan(1'b1, 19'h0, got);
      chk("R8 bidir captures pad", {28'd0, got[6:3]}, {28'd0, 4'b1001});
      chk("R9 constant cell", {31'd0, got[14]}, 32'd1);

      // R2: shift in then out again, same order
      scan(1'b0, 19'h53A1C, got);
      scan(1'b0, 19'h0, got);
      chk("R2 shift order", {13'd0, got}, {13'd0, 19'h53A1C});

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule